// File: doc/BRIEF.md
# Configurable Serial Host-Link UART

This block is a full-duplex asynchronous serial port for a host link. A 16-bit divisor sets a tick at sixteen times the bit rate. The transmitter and the receiver share that tick and otherwise run independently. A frame carries 7 or 8 data bits, least significant bit first. An optional parity bit follows the data, and the frame ends with one or two stop bits. The transmitter can hold the line low to send a break. The receiver reports framing errors, parity errors and incoming breaks.

Each received byte is held in a single holding register together with its error flags. A routing bit picks the consumer of that register. When the bit is 0 the byte goes to a CPU register port. When the bit is 1 it goes to an HCI packet engine. Each path has its own valid/ready handshake, and both paths share one data bus. The CPU gets one interrupt line built from four sources, each with its own mask bit. The HCI path gets one line that merges every receive error.

Top module: `uart_host_link`

## Requirements
- R1: Transmit and receive run at the same time without disturbing each other: a byte sent and a byte received in overlapping frames are both correct.
- R2: The oversampling tick occurs once every `cfg_divisor` clocks, and a divisor of 0 acts as 1. Every serial bit lasts 16 ticks.
- R3: `cfg_eight_bits`=1 selects 8 data bits and 0 selects 7. Bits go out and come in least significant first. A received 7-bit byte has bit 7 cleared.
- R4: `cfg_two_stop`=1 sends two stop bits and 0 sends one. The line is high during stop bits and while idle. `tx_ready` returns between (16n-1)·D and 16n·D+2 clocks after acceptance, where n is the number of bits in the frame and D is the divisor.
- R5: `cfg_parity` encodes the parity mode: 0 none, 1 even, 2 odd, 3 mark (always 1), 4 space (always 0), and 5 to 7 none. The transmitter inserts the parity bit after the data. The receiver sets `rx_flags[1]` when the received parity bit differs from the expected one.
- R6: A stop bit sampled as 0 sets `rx_flags[0]` (framing error).
- R7: While `cfg_force_break`=1, `serial_out` is 0 and `tx_ready` is 0 on every cycle.
- R8: A frame in which every sampled bit, stop included, is 0 is reported once. The record has data 0x00, `rx_flags[2]`=1 (break), `rx_flags[0]`=1 and `rx_flags[1]`=0. No further record appears until the line has returned high.
- R9: A start bit is accepted only if the line is still low at its middle (tick 8). A shorter low pulse produces no record.
- R10: `cfg_route_hci`=0 presents the held byte on `cpu_rx_valid`, and 1 presents it on `hci_rx_valid`. The other valid stays 0.
- R11: The holding register keeps one record until the selected path takes it. A frame that completes while the register is full is dropped.
- R12: `cpu_irq` is the OR of four masked sources: bit 0 a byte held on the CPU path, bit 1 `tx_ready`, bit 2 a held CPU byte with a framing or parity error, and bit 3 a held CPU byte marked as a break.
- R13: `hci_err_irq` is 1 exactly while a byte held on the HCI path carries any error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_divisor | input | 16 | Clocks per oversampling tick |
| cfg_eight_bits | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_two_stop | input | 1 | 1: two stop bits on transmit |
| cfg_parity | input | 3 | Parity mode code |
| cfg_force_break | input | 1 | Hold the transmit line low |
| cfg_route_hci | input | 1 | 0: CPU path, 1: HCI path |
| cfg_irq_mask | input | 4 | Enable for each CPU interrupt source |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmitter can accept a byte |
| serial_out | output | 1 | Serial transmit line |
| serial_in | input | 1 | Serial receive line |
| rx_data | output | 8 | Held received byte |
| rx_flags | output | 3 | {break, parity error, framing error} of held byte |
| cpu_rx_valid | output | 1 | Held byte offered to CPU path |
| cpu_rx_ready | input | 1 | CPU takes the byte |
| hci_rx_valid | output | 1 | Held byte offered to HCI path |
| hci_rx_ready | input | 1 | HCI engine takes the byte |
| cpu_irq | output | 1 | Masked CPU interrupt |
| hci_err_irq | output | 1 | Merged receive error interrupt for HCI |

## Verification
A wrong bit counter or tick phase in the transmitter shows as a wrong data bit, parity bit or stop level. The bench catches it at the middle of the affected bit, within 16·D clocks of the fault. A receiver fault, such as a missed start check or the loss of its break or all-zero history, shows at the held record one bit time after the stop bit. It appears as wrong data, wrong flags, or a record where none should exist. Faults in the holding register or the routing logic show within one clock in the valid lines and interrupts, which the bench compares on every cycle.

// File: rtl/uart_link_pkg.sv
// Shared types and helpers for the host-link UART.
// Assumes byte-wide payloads of at most 8 data bits.
package uart_link_pkg;

    typedef enum logic [2:0] {
        PAR_NONE  = 3'd0,
        PAR_EVEN  = 3'd1,
        PAR_ODD   = 3'd2,
        PAR_MARK  = 3'd3,
        PAR_SPACE = 3'd4
    } parity_e;

    typedef struct packed {
        logic [7:0] data;
        logic       brk;
        logic       par_err;
        logic       frm_err;
    } rx_rec_t;

    // True when the mode code calls for a parity bit
    function automatic logic parity_used(logic [2:0] mode);
        return (mode >= 3'd1) && (mode <= 3'd4);
    endfunction

    // Expected parity bit for a byte under the given mode and length
    function automatic logic parity_value(logic [2:0] mode, logic [7:0] d, logic eight);
        logic x;
        x = ^(eight ? d : {1'b0, d[6:0]});
        case (mode)
            3'd1:    return x;
            3'd2:    return ~x;
            3'd3:    return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/uart_tick_gen.sv
// Oversampling tick generator.
// Emits a one-cycle tick every 'divisor' clocks; a divisor of 0 acts as 1.
// Assumes the divisor is held steady while frames are in flight.
module uart_tick_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim_m1;

    // Last count value of one tick period
    always_comb lim_m1 = (divisor == '0) ? '0 : divisor - 1'b1;

    // Count clocks and pulse the tick at the end of each period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= lim_m1) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && divisor > 1) |=> !tick);

endmodule

// File: rtl/uart_tx_engine.sv
// Serial transmitter: start, 7/8 data bits LSB first, optional parity, 1/2 stop.
// Frame format is latched at acceptance; break forcing overrides the line.
module uart_tx_engine
    import uart_link_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       eight_bits,
    input  logic       two_stop,
    input  logic [2:0] parity_mode,
    input  logic       force_break,
    input  logic [7:0] data_in,
    input  logic       valid_in,
    output logic       ready_out,
    output logic       serial_out
);
    localparam int CNT_W = $clog2(OSR);

    typedef enum logic [2:0] {TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP} tx_state_e;

    tx_state_e        state;
    logic [CNT_W-1:0] tcnt;
    logic [2:0]       bitn;
    logic [7:0]       shreg;
    logic             eight_q, two_q, par_on_q, par_bit_q, stop2_q, line;
    logic             accept;

    // Handshake and line drive
    always_comb begin
        ready_out  = (state == TX_IDLE) && !force_break;
        accept     = valid_in && ready_out;
        serial_out = line && !force_break;
    end

    // Frame sequencer: one bit per OSR ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TX_IDLE; tcnt <= '0; bitn <= '0; shreg <= '0;
            eight_q <= 1'b1; two_q <= 1'b0; par_on_q <= 1'b0; par_bit_q <= 1'b0;
            stop2_q <= 1'b0; line <= 1'b1;
        end else if (state == TX_IDLE) begin
            line <= 1'b1;
            if (accept) begin
                state     <= TX_START;
                line      <= 1'b0;
                tcnt      <= '0;
                shreg     <= data_in;
                eight_q   <= eight_bits;
                two_q     <= two_stop;
                par_on_q  <= parity_used(parity_mode);
                par_bit_q <= parity_value(parity_mode, data_in, eight_bits);
            end
        end else if (tick) begin
            if (tcnt != CNT_W'(OSR - 1)) begin
                tcnt <= tcnt + 1'b1;
            end else begin
                tcnt <= '0;
                case (state)
                    TX_START: begin
                        state <= TX_DATA; bitn <= '0; line <= shreg[0];
                    end
                    TX_DATA: begin
                        if (bitn == (eight_q ? 3'd7 : 3'd6)) begin
                            if (par_on_q) begin
                                state <= TX_PAR; line <= par_bit_q;
                            end else begin
                                state <= TX_STOP; line <= 1'b1; stop2_q <= 1'b0;
                            end
                        end else begin
                            bitn  <= bitn + 1'b1;
                            shreg <= {1'b0, shreg[7:1]};
                            line  <= shreg[1];
                        end
                    end
                    TX_PAR: begin
                        state <= TX_STOP; line <= 1'b1; stop2_q <= 1'b0;
                    end
                    default: begin
                        if (two_q && !stop2_q) stop2_q <= 1'b1;
                        else                   state   <= TX_IDLE;
                    end
                endcase
            end
        end
    end

    // R4
    tx_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_out |-> serial_out);
    // R1
    tx_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !ready_out);
    // R4
    tx_stop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_STOP) |-> line);

endmodule

// File: rtl/uart_rx_engine.sv
// Serial receiver: synchronises the line, validates the start bit at mid-bit,
// samples each bit at its middle, checks parity and stop, and flags breaks.
// After a low stop bit it waits for the line to return high before hunting.
module uart_rx_engine
    import uart_link_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       eight_bits,
    input  logic [2:0] parity_mode,
    input  logic       serial_in,
    output logic       rec_valid,
    output rx_rec_t    rec
);
    localparam int CNT_W = $clog2(OSR);

    typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_WAIT_HIGH} rx_state_e;

    rx_state_e        state;
    logic             s1, rxd;
    logic [CNT_W-1:0] tcnt;
    logic [2:0]       bitn;
    logic [7:0]       shreg;
    logic             zeros, perr;

    // Two-flop synchroniser, idles high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1; rxd <= 1'b1;
        end else begin
            s1 <= serial_in; rxd <= s1;
        end
    end

    // Bit-centre sampler and record builder
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RX_IDLE; tcnt <= '0; bitn <= '0; shreg <= '0;
            zeros <= 1'b0; perr <= 1'b0; rec_valid <= 1'b0; rec <= '0;
        end else begin
            rec_valid <= 1'b0;
            if (state == RX_WAIT_HIGH) begin
                if (rxd) state <= RX_IDLE;
            end else if (tick) begin
                case (state)
                    RX_IDLE: begin
                        if (!rxd) begin
                            state <= RX_START; tcnt <= '0;
                        end
                    end
                    RX_START: begin
                        if (tcnt == CNT_W'(OSR / 2 - 1)) begin
                            tcnt <= '0;
                            if (rxd) begin
                                state <= RX_IDLE;
                            end else begin
                                state <= RX_DATA; bitn <= '0; shreg <= '0;
                                zeros <= 1'b1; perr <= 1'b0;
                            end
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    default: begin
                        if (tcnt != CNT_W'(OSR - 1)) begin
                            tcnt <= tcnt + 1'b1;
                        end else begin
                            tcnt  <= '0;
                            zeros <= zeros && !rxd;
                            case (state)
                                RX_DATA: begin
                                    shreg[bitn] <= rxd;
                                    if (bitn == (eight_bits ? 3'd7 : 3'd6))
                                        state <= parity_used(parity_mode) ? RX_PAR : RX_STOP;
                                    else
                                        bitn <= bitn + 1'b1;
                                end
                                RX_PAR: begin
                                    perr  <= (rxd != parity_value(parity_mode, shreg, eight_bits));
                                    state <= RX_STOP;
                                end
                                default: begin
                                    rec_valid   <= 1'b1;
                                    rec.data    <= shreg;
                                    rec.frm_err <= !rxd;
                                    rec.brk     <= !rxd && zeros;
                                    rec.par_err <= perr && !(!rxd && zeros);
                                    state       <= rxd ? RX_IDLE : RX_WAIT_HIGH;
                                end
                            endcase
                        end
                    end
                endcase
            end
        end
    end

    // R8
    rx_brk_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && rec.brk) |-> (rec.data == 8'h00 && rec.frm_err && !rec.par_err));
    // R3
    rx_seven_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && !eight_bits && $stable(eight_bits)) |-> !rec.data[7]);

endmodule

// File: rtl/uart_host_link.sv
// Top of the host-link UART: tick generator, transmitter, receiver, one-record
// holding register with CPU/HCI routing, and the two interrupt outputs.
// Assumes configuration inputs change only between frames.
module uart_host_link
    import uart_link_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int OSR   = 16,
    parameter int IRQ_N = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] cfg_divisor,
    input  logic             cfg_eight_bits,
    input  logic             cfg_two_stop,
    input  logic [2:0]       cfg_parity,
    input  logic             cfg_force_break,
    input  logic             cfg_route_hci,
    input  logic [IRQ_N-1:0] cfg_irq_mask,
    input  logic [7:0]       tx_data,
    input  logic             tx_valid,
    output logic             tx_ready,
    output logic             serial_out,
    input  logic             serial_in,
    output logic [7:0]       rx_data,
    output logic [2:0]       rx_flags,
    output logic             cpu_rx_valid,
    input  logic             cpu_rx_ready,
    output logic             hci_rx_valid,
    input  logic             hci_rx_ready,
    output logic             cpu_irq,
    output logic             hci_err_irq
);
    logic             tick;
    logic             rec_valid;
    rx_rec_t          rec;
    rx_rec_t          held;
    logic             held_v;
    logic             consume;
    logic [IRQ_N-1:0] irq_src;

    uart_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .divisor(cfg_divisor), .tick(tick));

    uart_tx_engine #(.OSR(OSR)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .eight_bits(cfg_eight_bits),
        .two_stop(cfg_two_stop), .parity_mode(cfg_parity), .force_break(cfg_force_break),
        .data_in(tx_data), .valid_in(tx_valid), .ready_out(tx_ready), .serial_out(serial_out));

    uart_rx_engine #(.OSR(OSR)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .eight_bits(cfg_eight_bits),
        .parity_mode(cfg_parity), .serial_in(serial_in), .rec_valid(rec_valid), .rec(rec));

    // Route the held record and form the handshake
    always_comb begin
        cpu_rx_valid = held_v && !cfg_route_hci;
        hci_rx_valid = held_v && cfg_route_hci;
        consume      = (cpu_rx_valid && cpu_rx_ready) || (hci_rx_valid && hci_rx_ready);
        rx_data      = held.data;
        rx_flags     = {held.brk, held.par_err, held.frm_err};
    end

    // Single holding register; new records are dropped while it is full
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_v <= 1'b0;
            held   <= '0;
        end else if (consume) begin
            held_v <= 1'b0;
        end else if (rec_valid && !held_v) begin
            held_v <= 1'b1;
            held   <= rec;
        end
    end

    // Interrupt sources; one mask bit per source, generated per index
    always_comb begin
        irq_src    = '0;
        irq_src[0] = cpu_rx_valid;
        irq_src[1] = tx_ready;
        if (IRQ_N > 2) irq_src[2 % IRQ_N] = cpu_rx_valid && (held.frm_err || held.par_err);
        if (IRQ_N > 3) irq_src[3 % IRQ_N] = cpu_rx_valid && held.brk;
    end

    // CPU interrupt is the OR of masked sources; HCI line merges all errors
    always_comb begin
        cpu_irq     = |(irq_src & cfg_irq_mask);
        hci_err_irq = hci_rx_valid && (held.frm_err || held.par_err || held.brk);
    end

    // R11
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held_v && !consume) |=> (held_v && $stable(rx_data) && $stable(rx_flags)));
    // R13
    hci_irq_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hci_err_irq |-> (hci_rx_valid && !cpu_rx_valid));
    // R10
    route_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cpu_rx_valid, hci_rx_valid}));

endmodule

// File: tb/test_uart_host_link.sv
module test_uart_host_link;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_divisor = 16'd2;
    logic        cfg_eight_bits = 1'b1, cfg_two_stop = 1'b0;
    logic [2:0]  cfg_parity = 3'd0;
    logic        cfg_force_break = 1'b0, cfg_route_hci = 1'b0;
    logic [3:0]  cfg_irq_mask = 4'b0000;
    logic [7:0]  tx_data = 8'h00;
    logic        tx_valid = 1'b0, serial_in = 1'b1;
    logic        cpu_rx_ready = 1'b0, hci_rx_ready = 1'b0;
    logic        tx_ready, serial_out, cpu_rx_valid, hci_rx_valid, cpu_irq, hci_err_irq;
    logic [7:0]  rx_data;
    logic [2:0]  rx_flags;

    int checks = 0, fails = 0, cyc = 0;
    bit mon_on = 1'b0;
    bit brk_expect = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    uart_host_link i_uart_host_link (
        .clk(clk), .rst_n(rst_n), .cfg_divisor(cfg_divisor), .cfg_eight_bits(cfg_eight_bits),
        .cfg_two_stop(cfg_two_stop), .cfg_parity(cfg_parity), .cfg_force_break(cfg_force_break),
        .cfg_route_hci(cfg_route_hci), .cfg_irq_mask(cfg_irq_mask), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .serial_out(serial_out), .serial_in(serial_in),
        .rx_data(rx_data), .rx_flags(rx_flags), .cpu_rx_valid(cpu_rx_valid),
        .cpu_rx_ready(cpu_rx_ready), .hci_rx_valid(hci_rx_valid), .hci_rx_ready(hci_rx_ready),
        .cpu_irq(cpu_irq), .hci_err_irq(hci_err_irq));

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    function automatic logic ref_parity(int pm, logic [7:0] d, int nb);
        logic x = 1'b0;
        for (int i = 0; i < nb; i++) x ^= d[i];
        case (pm)
            1: return x;
            2: return ~x;
            3: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // Per-clock reference model of routing, interrupts and break forcing
    always @(negedge clk) if (mon_on) begin
        logic ev, eh;
        ev = (cfg_irq_mask[0] && cpu_rx_valid) || (cfg_irq_mask[1] && tx_ready)
           || (cfg_irq_mask[2] && cpu_rx_valid && (rx_flags[0] || rx_flags[1]))
           || (cfg_irq_mask[3] && cpu_rx_valid && rx_flags[2]);
        eh = hci_rx_valid && (|rx_flags);
        check("R12 cpu_irq", cpu_irq, ev);
        check("R13 hci_err_irq", hci_err_irq, eh);
        check("R10 route", cfg_route_hci ? cpu_rx_valid : hci_rx_valid, 0);
        if (brk_expect) begin
            check("R7 break line", serial_out, 0);
            check("R7 break ready", tx_ready, 0);
        end
    end

    task automatic drive_bit(input logic b);
        serial_in = b;
        repeat (16 * int'(cfg_divisor)) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input int nb, input int pm, input logic stopv);
        drive_bit(1'b0);
        for (int i = 0; i < nb; i++) drive_bit(d[i]);
        if (pm >= 1 && pm <= 4) drive_bit(ref_parity(pm, d, nb));
        drive_bit(stopv);
        drive_bit(1'b1);
    endtask

    task automatic wait_rx(output bit got);
        got = 1'b0;
        for (int i = 0; i < 3000 && !got; i++) begin
            if (cpu_rx_valid || hci_rx_valid) got = 1'b1;
            else @(negedge clk);
        end
    endtask

    task automatic take();
        if (cfg_route_hci) hci_rx_ready = 1'b1; else cpu_rx_ready = 1'b1;
        @(negedge clk);
        hci_rx_ready = 1'b0; cpu_rx_ready = 1'b0;
        @(negedge clk);
    endtask

    task automatic expect_rx(input string req, input logic [7:0] d, input logic [2:0] f);
        bit got;
        wait_rx(got);
        check({req, " record present"}, got, 1);
        check({req, " data"}, rx_data, d);
        check({req, " flags"}, rx_flags, f);
        take();
    endtask

    // Send one byte and decode the line at bit centres; also times tx_ready
    task automatic tx_frame(input string req, input logic [7:0] d, input int nb, input int pm, input bit two);
        int c0, dur, n, dv;
        logic [7:0] got;
        logic b;
        dv = int'(cfg_divisor);
        tx_data = d; tx_valid = 1'b1;
        while (!tx_ready) @(negedge clk);
        @(posedge clk); c0 = cyc;
        @(negedge clk); tx_valid = 1'b0;
        while (serial_out) @(negedge clk);
        repeat (8 * dv) @(negedge clk);
        check({req, " start bit"}, serial_out, 0);
        got = 8'h00;
        for (int i = 0; i < nb; i++) begin
            repeat (16 * dv) @(negedge clk);
            got[i] = serial_out;
        end
        check({req, " R3 data bits"}, got, d & (nb == 8 ? 8'hFF : 8'h7F));
        if (pm >= 1 && pm <= 4) begin
            repeat (16 * dv) @(negedge clk);
            b = serial_out;
            check({req, " R5 parity bit"}, b, ref_parity(pm, d, nb));
        end
        repeat (16 * dv) @(negedge clk);
        check({req, " R4 stop1"}, serial_out, 1);
        if (two) begin
            repeat (16 * dv) @(negedge clk);
            check({req, " R4 stop2"}, serial_out, 1);
        end
        while (!tx_ready) @(negedge clk);
        dur = cyc - c0;
        n = 1 + nb + ((pm >= 1 && pm <= 4) ? 1 : 0) + (two ? 2 : 1);
        check({req, " R4 frame length"}, (dur >= (16 * n - 1) * dv && dur <= 16 * n * dv + 2), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        bit got;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        check("R4 reset tx_ready", tx_ready, 1);
        check("R4 reset line", serial_out, 1);
        check("R10 reset cpu valid", cpu_rx_valid, 0);
        check("R10 reset hci valid", hci_rx_valid, 0);
        check("R12 reset irq", cpu_irq, 0);
        mon_on = 1'b1;

        // R1 R2 R3: 8N1 both directions at once
        fork
            tx_frame("R1 tx 8N1", 8'hA5, 8, 0, 1'b0);
            begin send_frame(8'h3C, 8, 0, 1'b1); expect_rx("R1 rx 8N1", 8'h3C, 3'b000); end
        join

        // R3 R4 R5: 7 bits, even parity, two stop bits
        cfg_eight_bits = 1'b0; cfg_parity = 3'd1; cfg_two_stop = 1'b1;
        fork
            tx_frame("R4 tx 7E2", 8'h55, 7, 1, 1'b1);
            begin send_frame(8'h35, 7, 1, 1'b1); expect_rx("R3 rx 7E", 8'h35, 3'b000); end
        join

        // R5: odd parity, transmit and a bad received parity bit
        cfg_eight_bits = 1'b1; cfg_parity = 3'd2; cfg_two_stop = 1'b0;
        tx_frame("R5 tx odd", 8'h81, 8, 2, 1'b0);
        send_frame(8'h81, 8, 1, 1'b1);
        expect_rx("R5 rx odd bad", 8'h81, 3'b010);

        // R5: mark and space
        cfg_parity = 3'd3;
        tx_frame("R5 tx mark", 8'h0F, 8, 3, 1'b0);
        send_frame(8'h0F, 8, 4, 1'b1);
        expect_rx("R5 rx mark bad", 8'h0F, 3'b010);
        cfg_parity = 3'd4;
        tx_frame("R5 tx space", 8'hF0, 8, 4, 1'b0);
        send_frame(8'hF0, 8, 4, 1'b1);
        expect_rx("R5 rx space ok", 8'hF0, 3'b000);

        // R2: slower divisor
        cfg_parity = 3'd0; cfg_divisor = 16'd3;
        repeat (10) @(negedge clk);
        tx_frame("R2 tx div3", 8'hC3, 8, 0, 1'b0);
        send_frame(8'h69, 8, 0, 1'b1);
        expect_rx("R2 rx div3", 8'h69, 3'b000);
        cfg_divisor = 16'd2;
        repeat (10) @(negedge clk);

        // R6: framing error on a non-zero byte
        send_frame(8'h5A, 8, 0, 1'b0);
        expect_rx("R6 framing", 8'h5A, 3'b001);

        // R7: forced break
        cfg_force_break = 1'b1;
        @(negedge clk); brk_expect = 1'b1;
        tx_data = 8'hFF; tx_valid = 1'b1;
        repeat (200) @(negedge clk);
        tx_valid = 1'b0; brk_expect = 1'b0;
        cfg_force_break = 1'b0;
        @(negedge clk);
        check("R7 released line", serial_out, 1);

        // R8 R13: break detection on the HCI path
        cfg_route_hci = 1'b1;
        serial_in = 1'b0;
        repeat (12 * 32) @(negedge clk);
        check("R13 hci err irq on break", hci_err_irq, 1);
        expect_rx("R8 break record", 8'h00, 3'b101);
        repeat (200) @(negedge clk);
        check("R8 single break record", hci_rx_valid, 0);
        serial_in = 1'b1;
        repeat (64) @(negedge clk);
        send_frame(8'h81, 8, 0, 1'b1);
        wait_rx(got);
        check("R13 clean record no err irq", hci_err_irq, 0);
        check("R10 cpu valid off on hci route", cpu_rx_valid, 0);
        expect_rx("R8 after break", 8'h81, 3'b000);

        // R9: short low pulse is ignored
        cfg_route_hci = 1'b0;
        serial_in = 1'b0;
        repeat (8) @(negedge clk);
        serial_in = 1'b1;
        repeat (400) @(negedge clk);
        check("R9 glitch ignored", cpu_rx_valid, 0);

        // R11: second frame dropped while first held
        send_frame(8'h11, 8, 0, 1'b1);
        send_frame(8'h22, 8, 0, 1'b1);
        check("R11 first held", rx_data, 8'h11);
        take();
        repeat (20) @(negedge clk);
        check("R11 second dropped", cpu_rx_valid, 0);

        // R12: masks
        send_frame(8'h5A, 8, 0, 1'b0);
        wait_rx(got);
        cfg_irq_mask = 4'b0000; @(negedge clk);
        check("R12 all masked", cpu_irq, 0);
        cfg_irq_mask = 4'b0100; @(negedge clk);
        check("R12 error source", cpu_irq, 1);
        cfg_irq_mask = 4'b1000; @(negedge clk);
        check("R12 break source off", cpu_irq, 0);
        cfg_irq_mask = 4'b0001; @(negedge clk);
        check("R12 data source", cpu_irq, 1);
        take();
        check("R12 data source cleared", cpu_irq, 0);
        cfg_irq_mask = 4'b0010; @(negedge clk);
        check("R12 tx ready source", cpu_irq, 1);
        cfg_irq_mask = 4'b0000;
        repeat (4) @(negedge clk);

        mon_on = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule